// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block keeps a small, fully associative set of recent address translations in front of a page table walker. A lookup key is made of a segment number and a virtual page number. When the key is present, the physical address is returned in the same cycle as the request: the stored frame number in the upper bits and the untouched page offset in the lower bits.

When the key is absent, the block holds the request, raises a walk request toward an external walker, and waits. When the walker returns the frame, the block answers the held request in that same cycle and installs the translation. It fills an empty slot if one exists and otherwise replaces the slot chosen by a rotating pointer. Each entry carries a write permission bit. A write that hits a read-only entry is answered with a protection fault and is not walked. A flush input drops every translation at once, for use on a context switch.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1, and `walk_req` and `resp_valid` are 0.
- R2: An accepted request (`req_valid` and `req_ready` both 1) whose segment and page match a valid entry asserts `resp_valid` in the same cycle. `resp_paddr` is then the stored 12-bit frame in bits 23:12 and the request offset in bits 11:0.
- R3: An accepted request that matches no entry gives no response in that cycle. From the next cycle `walk_req` is 1 and `walk_seg`/`walk_vpn` show the missed key, held stable, while `req_ready` is 0, until a fill arrives.
- R4: A `fill_valid` pulse while `walk_req` is 1 asserts `resp_valid` in that cycle, with `resp_paddr` = {`fill_pfn`, held offset}. It returns the block to idle on the next cycle, and a later request with the same key hits with the filled frame.
- R5: `resp_fault` is 1 on a response exactly when the request was a write (`req_write`=1) and the translation is not writable, whether from a stored entry or from `fill_wr`. A faulting hit does not start a walk.
- R6: A fill installs into the lowest-numbered invalid entry whenever one exists, without moving the rotating pointer.
- R7: When all 16 entries are valid, a fill replaces the entry named by the rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such replacement. A flush does not reset it.
- R8: A cycle with `flush`=1 invalidates every entry, so later requests for earlier keys miss. `req_ready` is 0 in that cycle.
- R9: `fill_valid` while no walk is pending has no effect: no response is produced and nothing is installed.
- R10: A flush while a walk is pending does not cancel the walk. A flush in the same cycle as the fill still returns the translation, but does not keep it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_seg | input | 4 | Segment number of the request |
| req_vpn | input | 8 | Virtual page number of the request |
| req_off | input | 12 | Page offset of the request |
| req_write | input | 1 | Request is a write |
| resp_valid | output | 1 | Translation delivered this cycle |
| resp_paddr | output | 24 | Physical address {frame, offset} |
| resp_fault | output | 1 | Write to a read-only translation |
| walk_req | output | 1 | Walk request to the external walker |
| walk_seg | output | 4 | Segment of the key to walk |
| walk_vpn | output | 8 | Page number of the key to walk |
| fill_valid | input | 1 | Walker returns a translation |
| fill_pfn | input | 12 | Frame number returned by the walker |
| fill_wr | input | 1 | Returned translation is writable |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest case to reach is replacement by the rotating pointer, which can only happen once all sixteen entries hold distinct keys. The stimulus flushes, installs sixteen fresh keys, and then forces further misses. Which key then misses and which still hits shows where the pointer stood. A second flush followed by sixteen new installs shows that empty slots win over the pointer, and that the pointer kept its position across the flush. A run of random mixed traffic over more keys than the buffer holds, with random walker delays and occasional flushes, is compared cycle by cycle against a behavioural model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int SEG_W   = 4;
    localparam int VPN_W   = 8;
    localparam int OFF_W   = 12;
    localparam int PFN_W   = 12;
    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int PA_W    = PFN_W + OFF_W;

    typedef struct packed {
        logic             vld;
        logic [SEG_W-1:0] seg;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             wr;
    } xent_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } xst_t;

    typedef struct packed {
        xst_t                     st;
        xent_t [ENTRIES-1:0]      ent;
        logic  [IDX_W-1:0]        rr;
        logic  [SEG_W-1:0]        h_seg;
        logic  [VPN_W-1:0]        h_vpn;
        logic  [OFF_W-1:0]        h_off;
        logic                     h_wr;
    } xreg_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
(
    input  xent_t [ENTRIES-1:0] ent,
    input  logic  [SEG_W-1:0]   key_seg,
    input  logic  [VPN_W-1:0]   key_vpn,
    output logic                hit,
    output logic  [IDX_W-1:0]   hit_idx
);
    logic [ENTRIES-1:0] match;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = ent[g].vld && (ent[g].seg == key_seg) && (ent[g].vpn == key_vpn);
        end
    endgenerate

    // Tags are unique, so an OR of the matching indices is the encoded index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
(
    input  logic [ENTRIES-1:0] vld,
    input  logic [IDX_W-1:0]   rr,
    output logic [IDX_W-1:0]   victim,
    output logic               use_rr
);
    // Descending scan: the last assignment wins, so the lowest empty slot is chosen.
    always_comb begin
        victim = rr;
        use_rr = 1'b1;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                victim = IDX_W'(i);
                use_rr = 1'b0;
            end
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [OFF_W-1:0] req_off,
    input  logic             req_write,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             walk_req,
    output logic [SEG_W-1:0] walk_seg,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_wr,
    input  logic             flush
);
    localparam logic [IDX_W-1:0] RR_LAST = IDX_W'(ENTRIES - 1);

    xreg_t q, d;

    logic               waiting;
    logic [SEG_W-1:0]   key_seg;
    logic [VPN_W-1:0]   key_vpn;
    logic [ENTRIES-1:0] vld_vec;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim;
    logic               use_rr;
    logic [IDX_W-1:0]   slot;
    xent_t              sel;

    assign waiting = (q.st == ST_WALK);
    // While a walk is pending the matcher looks at the held key (refill dedup).
    assign key_seg = waiting ? q.h_seg : req_seg;
    assign key_vpn = waiting ? q.h_vpn : req_vpn;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_vld
            assign vld_vec[g] = q.ent[g].vld;
        end
    endgenerate

    xlat_match u_match (
        .ent     (q.ent),
        .key_seg (key_seg),
        .key_vpn (key_vpn),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    xlat_victim u_victim (
        .vld    (vld_vec),
        .rr     (q.rr),
        .victim (victim),
        .use_rr (use_rr)
    );

    always_comb begin
        d          = q;
        resp_valid = 1'b0;
        resp_paddr = '0;
        resp_fault = 1'b0;
        sel        = q.ent[hit_idx];
        slot       = hit ? hit_idx : victim;

        case (q.st)
            ST_IDLE: begin
                if (req_valid && !flush) begin
                    if (hit) begin
                        resp_valid = 1'b1;
                        resp_paddr = {sel.pfn, req_off};
                        resp_fault = req_write && !sel.wr;
                    end else begin
                        d.st    = ST_WALK;
                        d.h_seg = req_seg;
                        d.h_vpn = req_vpn;
                        d.h_off = req_off;
                        d.h_wr  = req_write;
                    end
                end
            end
            ST_WALK: begin
                if (fill_valid) begin
                    resp_valid     = 1'b1;
                    resp_paddr     = {fill_pfn, q.h_off};
                    resp_fault     = q.h_wr && !fill_wr;
                    d.ent[slot].vld = 1'b1;
                    d.ent[slot].seg = q.h_seg;
                    d.ent[slot].vpn = q.h_vpn;
                    d.ent[slot].pfn = fill_pfn;
                    d.ent[slot].wr  = fill_wr;
                    if (!hit && use_rr) begin
                        d.rr = (q.rr == RR_LAST) ? '0 : q.rr + 1'b1;
                    end
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                d.ent[i].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = !waiting && !flush;
    assign walk_req  = waiting;
    assign walk_seg  = q.h_seg;
    assign walk_vpn  = q.h_vpn;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SEG_W-1:0] req_seg,
    input logic [VPN_W-1:0] req_vpn,
    input logic             resp_valid,
    input logic             resp_fault,
    input logic             walk_req,
    input logic [SEG_W-1:0] walk_seg,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             fill_valid,
    input logic             flush
);
    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !fill_valid |=> walk_req && $stable(walk_seg) && $stable(walk_vpn));

    // R3
    walk_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !fill_valid |-> !resp_valid && !req_ready);

    // R3
    miss_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !resp_valid |=>
            walk_req && walk_seg == $past(req_seg) && walk_vpn == $past(req_vpn));

    // R4
    fill_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && fill_valid |-> resp_valid ##1 !walk_req);

    // R5
    fault_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && resp_valid && resp_fault |=> !walk_req);

    // R8
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready);

    // R9
    stray_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !walk_req && !req_valid |-> !resp_valid);
endmodule

bind xlat_cache xlat_cache_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_seg    (req_seg),
    .req_vpn    (req_vpn),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .walk_req   (walk_req),
    .walk_seg   (walk_seg),
    .walk_vpn   (walk_vpn),
    .fill_valid (fill_valid),
    .flush      (flush)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_seg = '0;
    logic [7:0]  req_vpn = '0;
    logic [11:0] req_off = '0;
    logic        req_write = 1'b0;
    logic        resp_valid;
    logic [23:0] resp_paddr;
    logic        resp_fault;
    logic        walk_req;
    logic [3:0]  walk_seg;
    logic [7:0]  walk_vpn;
    logic        fill_valid = 1'b0;
    logic [11:0] fill_pfn = '0;
    logic        fill_wr = 1'b0;
    logic        flush = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xlat_cache uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_vpn(req_vpn), .req_off(req_off), .req_write(req_write),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .walk_req(walk_req), .walk_seg(walk_seg), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_pfn(fill_pfn), .fill_wr(fill_wr),
        .flush(flush)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st;
    int          m_rr;
    bit          m_vld [16];
    logic [3:0]  m_seg [16];
    logic [7:0]  m_vpn [16];
    logic [11:0] m_pfn [16];
    bit          m_wr  [16];
    logic [3:0]  h_seg;
    logic [7:0]  h_vpn;
    logic [11:0] h_off;
    bit          h_wr;

    always @(negedge clk) begin : model
        int          hi;
        int          vi;
        logic [3:0]  ks;
        logic [7:0]  kv;
        bit          e_ready;
        bit          e_resp;
        bit          e_fault;
        logic [23:0] e_pa;
        string       tag;
        if (!rst_n) begin
            m_st = 0;
            m_rr = 0;
            for (int i = 0; i < 16; i++) m_vld[i] = 0;
        end else begin
            ks = (m_st == 1) ? h_seg : req_seg;
            kv = (m_st == 1) ? h_vpn : req_vpn;
            hi = -1;
            for (int i = 0; i < 16; i++)
                if (m_vld[i] && m_seg[i] == ks && m_vpn[i] == kv) hi = i;
            e_ready = (m_st == 0) && !flush;
            e_resp = 0; e_fault = 0; e_pa = '0;
            if (m_st == 0) begin
                tag = flush ? "R8" : (fill_valid ? "R9" : "R1");
                if (req_valid && !flush) begin
                    if (hi >= 0) begin
                        e_resp = 1;
                        e_pa = {m_pfn[hi], req_off};
                        e_fault = req_write && !m_wr[hi];
                        tag = e_fault ? "R5" : "R2";
                    end else tag = "R3";
                end
            end else begin
                tag = "R3";
                if (fill_valid) begin
                    e_resp = 1;
                    e_pa = {fill_pfn, h_off};
                    e_fault = h_wr && !fill_wr;
                    tag = flush ? "R10" : "R4";
                end
            end
            check(req_ready == e_ready, tag, "req_ready", 32'(req_ready), 32'(e_ready));
            check(walk_req == (m_st == 1), "R3", "walk_req", 32'(walk_req), 32'(m_st == 1));
            if (m_st == 1)
                check(walk_seg == h_seg && walk_vpn == h_vpn, "R3", "walk key",
                      {20'h0, walk_seg, walk_vpn}, {20'h0, h_seg, h_vpn});
            check(resp_valid == e_resp, tag, "resp_valid", 32'(resp_valid), 32'(e_resp));
            if (e_resp) begin
                check(resp_paddr == e_pa, tag, "resp_paddr", 32'(resp_paddr), 32'(e_pa));
                check(resp_fault == e_fault, (e_fault ? "R5" : tag), "resp_fault",
                      32'(resp_fault), 32'(e_fault));
            end
            // next state
            if (m_st == 0) begin
                if (req_valid && !flush && hi < 0) begin
                    m_st = 1;
                    h_seg = req_seg; h_vpn = req_vpn; h_off = req_off; h_wr = req_write;
                end
            end else if (fill_valid) begin
                if (hi >= 0) vi = hi;
                else begin
                    vi = -1;
                    for (int i = 15; i >= 0; i--) if (!m_vld[i]) vi = i;
                    if (vi < 0) begin
                        vi = m_rr;
                        m_rr = (m_rr + 1) % 16;
                    end
                end
                m_vld[vi] = 1; m_seg[vi] = h_seg; m_vpn[vi] = h_vpn;
                m_pfn[vi] = fill_pfn; m_wr[vi] = fill_wr;
                m_st = 0;
            end
            if (flush) for (int i = 0; i < 16; i++) m_vld[i] = 0;
        end
    end

    // ---------------- drivers (all start and end at posedge + 1) ----------------
    task automatic do_lookup(input logic [3:0] s, input logic [7:0] v, input logic [11:0] o,
                             input logic w, output bit hit, output logic [23:0] pa, output bit flt);
        @(posedge clk); #1;
        req_valid = 1; req_seg = s; req_vpn = v; req_off = o; req_write = w;
        #3;
        hit = resp_valid; pa = resp_paddr; flt = resp_fault;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic do_fill(input logic [11:0] pfn, input logic wr, input int delay, input bit fl,
                           output bit rv, output logic [23:0] pa, output bit flt);
        for (int k = 0; k < delay; k++) begin
            @(posedge clk); #1;
        end
        fill_valid = 1; fill_pfn = pfn; fill_wr = wr; flush = fl;
        #3;
        rv = resp_valid; pa = resp_paddr; flt = resp_fault;
        @(posedge clk); #1;
        fill_valid = 0; flush = 0;
    endtask

    task automatic access(input logic [3:0] s, input logic [7:0] v, input logic [11:0] o,
                          input logic w, input logic [11:0] pfn, input logic pw, input int delay,
                          output bit hit);
        bit rv; bit flt; logic [23:0] pa;
        do_lookup(s, v, o, w, hit, pa, flt);
        if (!hit) do_fill(pfn, pw, delay, 1'b0, rv, pa, flt);
    endtask

    task automatic do_flush();
        @(posedge clk); #1;
        flush = 1;
        #3;
        check(req_ready == 1'b0, "R8", "req_ready during flush", 32'(req_ready), 32'd0);
        @(posedge clk); #1;
        flush = 0;
    endtask

    task automatic expect_hit(input logic [3:0] s, input logic [7:0] v, input bit exp,
                              input string tag);
        bit hit;
        access(s, v, 12'h0, 1'b0, 12'hEEE, 1'b1, 1, hit);
        check(hit == exp, tag, "lookup hit", 32'(hit), 32'(exp));
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run did not complete act=running exp=done");
        finish_run();
    end

    initial begin
        bit hit; bit rv; bit flt; logic [23:0] pa;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'd1);
        check(walk_req == 1'b0, "R1", "walk_req in reset", 32'(walk_req), 32'd0);
        check(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
        rst_n = 1;

        // R3 miss then R4 fill, then R2 hit
        do_lookup(4'h1, 8'h10, 12'h345, 1'b0, hit, pa, flt);
        check(!hit, "R3", "first lookup misses", 32'(hit), 32'd0);
        do_fill(12'hA01, 1'b1, 2, 1'b0, rv, pa, flt);
        check(rv && pa == 24'hA01345, "R4", "fill response paddr", 32'(pa), 32'hA01345);
        do_lookup(4'h1, 8'h10, 12'h7FF, 1'b1, hit, pa, flt);
        check(hit && pa == 24'hA017FF, "R2", "hit paddr", 32'(pa), 32'hA017FF);
        check(!flt, "R5", "write to writable entry", 32'(flt), 32'd0);

        // R5 write protection
        access(4'h2, 8'h33, 12'h000, 1'b0, 12'h0B2, 1'b0, 0, hit);
        do_lookup(4'h2, 8'h33, 12'h020, 1'b1, hit, pa, flt);
        check(hit && flt, "R5", "write to read-only faults", 32'(flt), 32'd1);
        #3;
        check(walk_req == 1'b0, "R5", "no walk after fault", 32'(walk_req), 32'd0);
        do_lookup(4'h2, 8'h33, 12'h020, 1'b0, hit, pa, flt);
        check(hit && !flt, "R5", "read of read-only ok", 32'(flt), 32'd0);
        do_lookup(4'h2, 8'h77, 12'h001, 1'b1, hit, pa, flt);
        do_fill(12'h0C3, 1'b0, 1, 1'b0, rv, pa, flt);
        check(rv && flt, "R5", "fill of read-only for write", 32'(flt), 32'd1);

        // R9 stray fill
        do_fill(12'hFFF, 1'b1, 0, 1'b0, rv, pa, flt);
        check(!rv, "R9", "stray fill gives no response", 32'(rv), 32'd0);
        do_lookup(4'h0, 8'h00, 12'h000, 1'b0, hit, pa, flt);
        check(!hit, "R9", "stray fill installed nothing", 32'(hit), 32'd0);
        do_fill(12'h111, 1'b1, 0, 1'b0, rv, pa, flt);

        // R8 flush
        do_flush();
        expect_hit(4'h1, 8'h10, 1'b0, "R8");
        expect_hit(4'h2, 8'h33, 1'b0, "R8");

        // R7 rotating replacement
        do_flush();
        for (int i = 0; i < 16; i++) access(4'h4, 8'(i), 12'h0, 1'b0, 12'(12'h100 + i), 1'b1, 0, hit);
        for (int i = 0; i < 16; i++) expect_hit(4'h4, 8'(i), 1'b1, "R7");
        expect_hit(4'h5, 8'h00, 1'b0, "R7");   // evicts slot 0
        expect_hit(4'h4, 8'h01, 1'b1, "R7");
        expect_hit(4'h4, 8'h00, 1'b0, "R7");   // evicts slot 1
        expect_hit(4'h4, 8'h02, 1'b1, "R7");
        expect_hit(4'h4, 8'h01, 1'b0, "R7");   // evicts slot 2, pointer now 3

        // R6 empty slots first, pointer kept over flush
        do_flush();
        for (int i = 0; i < 16; i++) access(4'h6, 8'(i), 12'h0, 1'b0, 12'(12'h200 + i), 1'b1, 0, hit);
        for (int i = 0; i < 16; i++) expect_hit(4'h6, 8'(i), 1'b1, "R6");
        expect_hit(4'h7, 8'h00, 1'b0, "R6");   // evicts slot 3
        expect_hit(4'h6, 8'h02, 1'b1, "R6");
        expect_hit(4'h6, 8'h04, 1'b1, "R6");
        expect_hit(4'h6, 8'h03, 1'b0, "R6");

        // R10 flush during a pending walk
        do_lookup(4'h8, 8'h01, 12'h0AB, 1'b0, hit, pa, flt);
        do_flush();
        #3;
        check(walk_req == 1'b1, "R10", "walk kept after flush", 32'(walk_req), 32'd1);
        do_fill(12'h321, 1'b1, 0, 1'b0, rv, pa, flt);
        check(rv && pa == 24'h3210AB, "R10", "fill after flush", 32'(pa), 32'h3210AB);
        expect_hit(4'h8, 8'h01, 1'b1, "R10");
        do_lookup(4'h8, 8'h02, 12'h0CD, 1'b0, hit, pa, flt);
        do_fill(12'h654, 1'b1, 1, 1'b1, rv, pa, flt);
        check(rv && pa == 24'h6540CD, "R10", "fill with flush answered", 32'(pa), 32'h6540CD);
        expect_hit(4'h8, 8'h02, 1'b0, "R10");

        // mixed random traffic, checked every cycle by the model
        for (int n = 0; n < 400; n++) begin
            logic [3:0] s;
            logic [7:0] v;
            s = 4'($urandom_range(0, 1));
            v = 8'($urandom_range(0, 11));
            if ($urandom_range(0, 24) == 0) do_flush();
            access(s, v, 12'($urandom), 1'($urandom), 12'($urandom), 1'($urandom),
                   $urandom_range(0, 3), hit);
        end

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule